// File: doc/BRIEF.md
# Serial Byte Memory with SPI Slave Port

This block models a byte-organised serial memory that sits behind an SPI slave port. A host selects it with an active-low chip select. The host shifts in an 8-bit command, an optional 16-bit address and data bytes. The block answers with array contents or with its status byte. Array writes land in the same system clock cycle that the last bit of each byte arrives, so a host can stream bytes at full serial rate with no polling. A write-enable latch must be armed before any write is accepted. A two-bit protection field fences off the upper part of the array. An enable bit combined with an active-low protect pin can freeze the status byte itself.

All pins are sampled by a free-running system clock through a synchronizer, and serial clock edges are detected from the sampled level. The SPI clock can therefore idle low or high (modes 0 and 3), and the rest of the chip sees a single clock domain. An active-low hold input pauses a frame at any bit and lets it resume later. The array depth is set by an address-width parameter, 14 bits (16,384 bytes) by default.

Top module: `spi_mem_slave`

## Requirements
- R1: While chip select is high, the serial output enable is low, and serial clock and data activity change no state. Every new selection starts decoding a fresh command byte, even if the previous frame stopped in the middle of a byte.
- R2: Serial input is captured on rising serial-clock edges and serial output changes after falling edges. Both idle levels of the serial clock (mode 0 low, mode 3 high) give identical results.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch is visible as bit 1 of the status byte.
- R4: Command 0x03, followed by a high then low address byte, returns array bytes MSB first from that address. Only the low ADDR_W address bits are used. Reading continues while chip select stays low, and the address wraps from the top address to 0.
- R5: Command 0x02, followed by a two-byte address, stores each following data byte when its eighth bit arrives. The address increments per byte and wraps the same way as R4, with no wait between bytes.
- R6: While the write-enable latch is clear, array writes and status writes are ignored.
- R7: The write-enable latch clears when chip select rises after any frame whose command byte was 0x02 or 0x01, whether or not the write was accepted.
- R8: Command 0x05 returns the status byte {WPEN, 0, 0, 0, BP[1:0], WEL, 0} (bit 7 down to bit 0), repeated for as long as chip select stays low. Command 0x01 copies data bits 7, 3 and 2 of the first data byte into WPEN and BP.
- R9: A status write is ignored while the write-protect pin is low and WPEN is 1. It is accepted with the pin low if WPEN is 0.
- R10: BP selects the protected region: 00 nothing, 01 the top quarter of the array, 10 the top half, 11 all of it. Writes into the protected region are dropped.
- R11: While hold is low, the output enable is low and serial clock and data are ignored. When hold returns high, the frame continues from the bit where it stopped.
- R12: After reset the status byte is 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause frame while low |
| wp_n | input | 1 | Status-write protect pin, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Tri-state enable for so |

## Verification
A full-array burst write in mode 0 is read back in mode 3 from a different start address, with hold pulses in the middle of bytes. This separates address wrap, address masking, bit ordering and pause handling from one another. Short windows that straddle each protection boundary, for each BP value, show whether the region test uses the right address bits and thresholds. Status writes under the four combinations of pin level and WPEN distinguish the lock condition from the plain write-enable gate. Junk clocking while deselected and truncated frames confirm that each selection restarts command decoding.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_AHI,
        PH_ALO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
    } status_t;

    function automatic logic [7:0] status_pack(input status_t s);
        return {s.wpen, 3'b000, s.bp, s.wel, 1'b0};
    endfunction

    // top2 = two most significant address bits of the target byte
    function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/byte_array.sv
module byte_array #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    import spi_mem_pkg::*;

    localparam int NPINS = 5;
    localparam logic [NPINS-1:0] PIN_IDLE = 5'b10011;

    logic [NPINS-1:0] pins_s;
    logic cs_s, sclk_s, si_s, hold_s, wp_s;
    logic sclk_d, cs_d;
    logic active, rise, fall, cs_rise, byte_done;

    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_next;
    logic [7:0]        op;
    logic [7:0]        tx_sr;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] load_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    status_t           st;
    logic              wr_frame;
    logic              so_q;
    logic              mem_we;
    logic              sr_write_ok;

    pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, sclk, si, hold_n, wp_n}), .q(pins_s)
    );
    assign {cs_s, sclk_s, si_s, hold_s, wp_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign active    = ~cs_s & hold_s;
    assign rise      = active & sclk_s & ~sclk_d;
    assign fall      = active & ~sclk_s & sclk_d;
    assign cs_rise   = cs_s & ~cs_d;
    assign rx_next   = {rx_sr, si_s};
    assign byte_done = rise & (bit_cnt == 3'd7);

    // address capture: a high-byte register only exists when the array needs it
    if (ADDR_W > 8) begin : g_wide
        logic [ADDR_W-9:0] hi_q;
        always_ff @(posedge clk) begin
            if (rst) hi_q <= '0;
            else if (byte_done && phase == PH_AHI) hi_q <= rx_next[ADDR_W-9:0];
        end
        assign load_addr = {hi_q, rx_next};
    end else begin : g_narrow
        assign load_addr = rx_next[ADDR_W-1:0];
    end

    assign rd_addr     = (phase == PH_ALO) ? load_addr : ptr;
    assign sr_write_ok = st.wel & ~(~wp_s & st.wpen);
    assign mem_we      = byte_done && phase == PH_DATA && op == OP_WRITE && st.wel
                         && !region_locked(st.bp, ptr[ADDR_W-1 -: 2]);

    byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(ptr), .wdata(rx_next),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            op       <= '0;
            tx_sr    <= '0;
            ptr      <= '0;
            st       <= '0;
            wr_frame <= 1'b0;
            so_q     <= 1'b0;
        end else if (cs_s) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            if (cs_rise && wr_frame) st.wel <= 1'b0;
            wr_frame <= 1'b0;
        end else begin
            if (rise) begin
                rx_sr   <= rx_next[6:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (fall && phase == PH_DATA) begin
                so_q  <= tx_sr[7];
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
            if (byte_done) begin
                case (phase)
                    PH_CMD: begin
                        op <= rx_next;
                        case (rx_next)
                            OP_WREN:  begin st.wel <= 1'b1; phase <= PH_SKIP; end
                            OP_WRDI:  begin st.wel <= 1'b0; phase <= PH_SKIP; end
                            OP_RDSR:  begin tx_sr <= status_pack(st); phase <= PH_DATA; end
                            OP_WRSR:  begin wr_frame <= 1'b1; phase <= PH_DATA; end
                            OP_READ:  phase <= PH_AHI;
                            OP_WRITE: begin wr_frame <= 1'b1; phase <= PH_AHI; end
                            default:  phase <= PH_SKIP;
                        endcase
                    end
                    PH_AHI: phase <= PH_ALO;
                    PH_ALO: begin
                        phase <= PH_DATA;
                        if (op == OP_READ) begin
                            tx_sr <= rd_data;
                            ptr   <= load_addr + 1'b1;
                        end else begin
                            ptr <= load_addr;
                        end
                    end
                    PH_DATA: begin
                        case (op)
                            OP_READ: begin tx_sr <= rd_data; ptr <= ptr + 1'b1; end
                            OP_WRITE: ptr <= ptr + 1'b1;
                            OP_RDSR: tx_sr <= status_pack(st);
                            OP_WRSR: begin
                                if (sr_write_ok) begin
                                    st.wpen <= rx_next[7];
                                    st.bp   <= rx_next[3:2];
                                end
                                phase <= PH_SKIP;
                            end
                            default: phase <= PH_SKIP;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign so    = so_q;
    assign so_oe = active && phase == PH_DATA && (op == OP_READ || op == OP_RDSR);

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       hold_n,
    input logic       wp_n,
    input logic       so_oe,
    input logic       mem_we,
    input logic       wel,
    input logic       wpen,
    input logic [1:0] bp,
    input logic [1:0] waddr_top,
    input logic [2:0] bit_cnt
);

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R1

    AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !$past(hold_n) && !$past(hold_n, 2) && !$past(hold_n, 3)) |-> !so_oe); // R11

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !$past(hold_n) && !$past(hold_n, 2) && !$past(cs_n, 2) && !$past(cs_n, 1))
        |=> $stable(bit_cnt)); // R11

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wel); // R6

    AST_WRITE_OUTSIDE_FENCE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (bp != 2'b11) && !(bp == 2'b10 && waddr_top[1])); // R10

    AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && !$past(wp_n) && !$past(wp_n, 2) && !$past(wp_n, 3) && wpen)
        |=> ($stable(wpen) && $stable(bp))); // R9

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .wp_n(wp_n),
    .so_oe(so_oe), .mem_we(mem_we), .wel(st.wel), .wpen(st.wpen), .bp(st.bp),
    .waddr_top(ptr[ADDR_W-1 -: 2]), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int H = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;

    always #2 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW)) u0 (.*);

    int   n_chk = 0, n_fail = 0;
    bit   m3 = 1'b0;
    bit   exp_wel = 1'b0, exp_wpen = 1'b0;
    logic [1:0] exp_bp = 2'b00;
    logic [7:0] refm [DEPTH];
    logic [7:0] junk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int a);
        return 8'((a * 29 + seed * 71 + 5) ^ (a >> 3));
    endfunction

    function automatic bit fenced(input logic [1:0] bp, input int a);
        case (bp)
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {exp_wpen, 3'b000, exp_bp, exp_wel, 1'b0};
    endfunction

    task automatic do_hold();
        tick(H);
        hold_n = 1'b0;
        tick(H);
        check_eq("R11 hiz", int'(so_oe), 0);
        sclk = ~sclk; si = ~si;
        tick(H);
        sclk = ~sclk;
        tick(H);
        hold_n = 1'b1;
        tick(H);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit hold_mid, input int nb);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            if (m3) sclk = 1'b0;
            si = tx[i];
            tick(H);
            rx[i] = so;
            sclk = 1'b1;
            tick(H);
            if (!m3) sclk = 1'b0;
            if (hold_mid && i == 4) do_hold();
        end
    endtask

    task automatic sel();
        sclk = m3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic frame_op(input logic [7:0] opc);
        sel(); xfer(opc, junk, 1'b0, 8); desel();
        if (opc == 8'h06) exp_wel = 1'b1;
        if (opc == 8'h04) exp_wel = 1'b0;
    endtask

    task automatic check_status(input string tag);
        logic [7:0] s;
        sel(); xfer(8'h05, junk, 1'b0, 8); xfer(8'h00, s, 1'b0, 8); desel();
        check_eq(tag, int'(s), int'(exp_status()));
    endtask

    task automatic frame_wrsr(input logic [7:0] v);
        sel(); xfer(8'h01, junk, 1'b0, 8); xfer(v, junk, 1'b0, 8); desel();
        if (exp_wel && !(!wp_n && exp_wpen)) begin
            exp_wpen = v[7];
            exp_bp   = v[3:2];
        end
        exp_wel = 1'b0;
    endtask

    task automatic frame_write(input logic [15:0] start, input int n, input int seed);
        sel();
        xfer(8'h02, junk, 1'b0, 8); xfer(start[15:8], junk, 1'b0, 8); xfer(start[7:0], junk, 1'b0, 8);
        for (int k = 0; k < n; k++) begin
            int a;
            logic [7:0] v;
            a = (int'(start) + k) % DEPTH;
            v = pat(seed, a);
            xfer(v, junk, 1'b0, 8);
            if (exp_wel && !fenced(exp_bp, a)) refm[a] = v;
        end
        desel();
        exp_wel = 1'b0;
    endtask

    task automatic frame_read(input logic [15:0] start, input int n, input string tag, input bit holds);
        logic [7:0] r;
        sel();
        xfer(8'h03, junk, 1'b0, 8); xfer(start[15:8], junk, 1'b0, 8); xfer(start[7:0], junk, 1'b0, 8);
        for (int k = 0; k < n; k++) begin
            int a;
            a = (int'(start) + k) % DEPTH;
            xfer(8'h00, r, holds && (k % 37 == 5), 8);
            check_eq(tag, int'(r), int'(refm[a]));
        end
        desel();
    endtask

    task automatic fence_round(input logic [7:0] sr, input logic [15:0] start, input int n, input int seed);
        frame_op(8'h06);
        frame_wrsr(sr);
        check_status("R8 status after write");
        frame_op(8'h06);
        m3 = ~m3;
        frame_write(start, n, seed);
        m3 = ~m3;
        frame_read(start - 16'd4, n + 8, "R10 fenced write", 1'b0);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        check_eq("R12 oe after reset", int'(so_oe), 0);
        check_status("R12 status after reset");

        // R3 arm latch, then R5 full burst from a masked address (R4), mode 0
        m3 = 1'b0;
        frame_op(8'h06);
        check_status("R3 latch set");
        frame_write(16'h3F80, DEPTH, 1);
        check_status("R7 latch cleared after write");

        // R2 / R4 / R5 / R11: mode 3 readback with wrap and hold pulses
        m3 = 1'b1;
        frame_read(16'hA5C0, DEPTH + 3, "R2/R4/R5 readback", 1'b1);

        // R6: write with latch clear leaves data
        frame_write(16'h0020, 2, 9);
        m3 = 1'b0;
        frame_read(16'h0020, 2, "R6 unarmed write", 1'b0);
        frame_wrsr(8'h8C);
        check_status("R6 unarmed status write");

        // R3 disable
        frame_op(8'h06);
        check_status("R3 latch set again");
        frame_op(8'h04);
        check_status("R3 latch cleared by 0x04");

        // R8: status write and repeated status bytes
        frame_op(8'h06);
        frame_wrsr(8'hFB);
        check_status("R7/R8 status 0x88");
        begin
            logic [7:0] s;
            sel(); xfer(8'h05, junk, 1'b0, 8);
            for (int k = 0; k < 3; k++) begin
                xfer(8'h00, s, 1'b0, 8);
                check_eq("R8 repeated status", int'(s), int'(exp_status()));
            end
            desel();
        end

        // R10 upper half fenced
        frame_op(8'h06);
        check_status("R3 latch under fence");
        m3 = 1'b1;
        frame_write(16'h0078, 16, 3);
        m3 = 1'b0;
        frame_read(16'h0070, 32, "R10 upper half", 1'b0);

        // R9: locked by pin + WPEN
        wp_n = 1'b0;
        frame_op(8'h06);
        frame_wrsr(8'h00);
        check_status("R9 locked status write");
        wp_n = 1'b1;
        fence_round(8'h04, 16'h00B8, 16, 4);
        wp_n = 1'b0;
        fence_round(8'h0C, 16'h00F8, 16, 5);
        check_status("R9 pin low with WPEN clear");
        wp_n = 1'b1;
        fence_round(8'h00, 16'h00F8, 16, 6);

        // R1: clocking while deselected, then a truncated frame
        frame_op(8'h06);
        cs_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            si = k[1];
            sclk = ~sclk;
            tick(H);
            check_eq("R1 oe while deselected", int'(so_oe), 0);
        end
        sclk = m3;
        tick(H);
        check_status("R1 latch untouched by deselected clocks");
        sel(); xfer(8'h02, junk, 1'b0, 4); desel();
        check_status("R1 fresh frame after partial byte");
        m3 = 1'b1;
        frame_read(16'h00FE, 4, "R1/R4 read after partial frame", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule